// File: doc/BRIEF.md
# SDI Timing Reference Decoder

This block watches a 10-bit serial digital video word stream and finds the four-word timing references that mark the edges of the active picture on every line. A word is accepted only on clock cycles where the clock-enable input is high. So the block can sit directly behind a receiver whose word rate is lower than its clock. Each reference starts with the fixed three-word preamble of all ones, all zeros and all zeros. The fourth word is the XYZ word. It tells the two kinds of reference apart: end of active video (EAV) or start of active video (SAV). It also carries the field bit and the vertical-blanking bit.

A small state machine tracks progress through the preamble. Its states are `ST_HUNT` (no match), `ST_GOT_ONES` (all-ones word seen), `ST_GOT_ZERO1` (first zero word seen) and `ST_GOT_ZERO2` (full preamble seen, the next word is the XYZ word). The transitions take place on enabled words only:
- An all-ones word moves to `ST_GOT_ONES` from any state.
- A zero word advances `ST_GOT_ONES` to `ST_GOT_ZERO1`, and `ST_GOT_ZERO1` to `ST_GOT_ZERO2`.
- Any other word returns to `ST_HUNT`.
- From `ST_GOT_ZERO2` the next word is always taken as the XYZ word. The machine then goes back to `ST_HUNT`, or to `ST_GOT_ONES` if that word was all ones.

The XYZ word is checked against the eight legal codes. A legal code produces one-clock pulses on the reference, EAV or SAV outputs, and updates the held field and vertical-blanking outputs. Any other code produces a one-clock bad-reference pulse and leaves the held state as it was.

Top module: `sdi_trs_decoder`

## Requirements
- R1: A synchronous reset clears all outputs to 0 and returns the matcher to `ST_HUNT`. A preamble that was partly received before the reset does not complete after it.
- R2: Words presented while `ce` is low are ignored. They neither advance nor break a match, and a pulse only ever follows a cycle with `ce` high.
- R3: After the words 0x3FF, 0x000, 0x000 and a legal XYZ word have been accepted, `ref_seen` is high for the clock cycle that follows the edge that accepted the XYZ word.
- R4: The legal EAV codes are 0x274, 0x2D8, 0x368 and 0x3C4. The legal SAV codes are 0x200, 0x2AC, 0x31C and 0x3B0. `is_eav` or `is_sav` pulses together with `ref_seen`, never both at once.
- R5: `field` takes the value of XYZ bit 8 and `vblank` takes the value of XYZ bit 7 of a legal reference. For EAV these are F=0,V=0 for 0x274; F=0,V=1 for 0x2D8; F=1,V=0 for 0x368; F=1,V=1 for 0x3C4. For SAV they are F=0,V=0 for 0x200; F=0,V=1 for 0x2AC; F=1,V=0 for 0x31C; F=1,V=1 for 0x3B0. Both outputs hold their value until the next legal reference.
- R6: A fourth word outside the eight legal codes pulses `bad_ref` for one cycle. In that case `ref_seen`, `is_eav` and `is_sav` stay low, and `field` and `vblank` are unchanged.
- R7: An all-ones word always restarts the preamble, even partway through a match. So 0x3FF,0x000,0x3FF,0x000,0x000,XYZ and 0x3FF,0x3FF,0x000,0x000,XYZ are both recognised.
- R8: Any word other than the expected one inside the preamble abandons the match. The following words are then not decoded as an XYZ word.
- R9: Every pulse output lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Word enable; `din` is accepted when high |
| din | input | 10 | Video word |
| ref_seen | output | 1 | Pulse: legal timing reference decoded |
| is_eav | output | 1 | Pulse: the reference is an EAV |
| is_sav | output | 1 | Pulse: the reference is an SAV |
| bad_ref | output | 1 | Pulse: fourth word after a preamble is not a legal code |
| field | output | 1 | Held field bit of the last legal reference |
| vblank | output | 1 | Held vertical-blanking bit of the last legal reference |

## Verification
If the matcher state is wrong, the error shows at the ports within the next enabled word or two. A reference goes missing, or a pulse appears after a broken or reset-interrupted preamble, one clock after the would-be XYZ word. A wrong decode of the field or blanking bit shows on `field` or `vblank` in the cycle after the reference. An illegal code that is allowed to update the held state shows in that same cycle. The bench therefore checks every output directly after each fourth word and again one idle cycle later, which also catches pulses that last longer than one cycle.

// File: rtl/sdi_trs_pkg.sv
package sdi_trs_pkg;

    typedef enum logic [1:0] {
        ST_HUNT      = 2'd0,
        ST_GOT_ONES  = 2'd1,
        ST_GOT_ZERO1 = 2'd2,
        ST_GOT_ZERO2 = 2'd3
    } trs_state_t;

    typedef struct packed {
        logic legal;
        logic eav;
        logic field;
        logic vblank;
    } xyz_info_t;

endpackage

// File: rtl/trs_preamble_fsm.sv
module trs_preamble_fsm
    import sdi_trs_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [WORD_W-1:0] din,
    output logic              xyz_strobe
);
    localparam logic [WORD_W-1:0] ALL_ONES  = {WORD_W{1'b1}};
    localparam logic [WORD_W-1:0] ALL_ZEROS = {WORD_W{1'b0}};

    trs_state_t state_q;
    trs_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        xyz_strobe = 1'b0;
        if (ce) begin
            unique case (state_q)
                ST_HUNT: begin
                    state_d = (din == ALL_ONES) ? ST_GOT_ONES : ST_HUNT;
                end
                ST_GOT_ONES: begin
                    if (din == ALL_ZEROS)     state_d = ST_GOT_ZERO1;
                    else if (din == ALL_ONES) state_d = ST_GOT_ONES;
                    else                      state_d = ST_HUNT;
                end
                ST_GOT_ZERO1: begin
                    if (din == ALL_ZEROS)     state_d = ST_GOT_ZERO2;
                    else if (din == ALL_ONES) state_d = ST_GOT_ONES;
                    else                      state_d = ST_HUNT;
                end
                ST_GOT_ZERO2: begin
                    xyz_strobe = 1'b1;
                    state_d    = (din == ALL_ONES) ? ST_GOT_ONES : ST_HUNT;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

endmodule

// File: rtl/xyz_classifier.sv
module xyz_classifier
    import sdi_trs_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic [WORD_W-1:0] xyz,
    output xyz_info_t         info
);
    localparam int PAD_W = WORD_W - 8;

    logic       f_bit;
    logic       v_bit;
    logic       h_bit;
    logic [3:0] prot_seen;
    logic [3:0] prot_want;

    always_comb begin
        f_bit     = xyz[WORD_W-2];
        v_bit     = xyz[WORD_W-3];
        h_bit     = xyz[WORD_W-4];
        prot_seen = xyz[WORD_W-5 -: 4];
        prot_want = {v_bit ^ h_bit, f_bit ^ h_bit, f_bit ^ v_bit, f_bit ^ v_bit ^ h_bit};
        info.legal  = xyz[WORD_W-1] && (prot_seen == prot_want) &&
                      (xyz[PAD_W-1:0] == '0);
        info.eav    = h_bit;
        info.field  = f_bit;
        info.vblank = v_bit;
    end

endmodule

// File: rtl/trs_flag_reg.sv
module trs_flag_reg
    import sdi_trs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      strobe,
    input  xyz_info_t info,
    output logic      ref_seen,
    output logic      is_eav,
    output logic      is_sav,
    output logic      bad_ref,
    output logic      field,
    output logic      vblank
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_seen <= 1'b0;
            is_eav   <= 1'b0;
            is_sav   <= 1'b0;
            bad_ref  <= 1'b0;
            field    <= 1'b0;
            vblank   <= 1'b0;
        end else begin
            ref_seen <= strobe && info.legal;
            is_eav   <= strobe && info.legal && info.eav;
            is_sav   <= strobe && info.legal && !info.eav;
            bad_ref  <= strobe && !info.legal;
            if (strobe && info.legal) begin
                field  <= info.field;
                vblank <= info.vblank;
            end
        end
    end

endmodule

// File: rtl/sdi_trs_decoder.sv
module sdi_trs_decoder
    import sdi_trs_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic [WORD_W-1:0] din,
    output logic              ref_seen,
    output logic              is_eav,
    output logic              is_sav,
    output logic              bad_ref,
    output logic              field,
    output logic              vblank
);
    logic      xyz_strobe;
    xyz_info_t xyz_info;

    trs_preamble_fsm #(.WORD_W(WORD_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ce         (ce),
        .din        (din),
        .xyz_strobe (xyz_strobe)
    );

    xyz_classifier #(.WORD_W(WORD_W)) u_cls (
        .xyz  (din),
        .info (xyz_info)
    );

    trs_flag_reg u_out (
        .clk      (clk),
        .rst      (rst),
        .strobe   (xyz_strobe),
        .info     (xyz_info),
        .ref_seen (ref_seen),
        .is_eav   (is_eav),
        .is_sav   (is_sav),
        .bad_ref  (bad_ref),
        .field    (field),
        .vblank   (vblank)
    );

endmodule

// File: rtl/sdi_trs_decoder_chk.sv
module sdi_trs_decoder_chk (
    input logic clk,
    input logic rst,
    input logic ce,
    input logic ref_seen,
    input logic is_eav,
    input logic is_sav,
    input logic bad_ref,
    input logic field,
    input logic vblank
);
    AST_PULSE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        (ref_seen || bad_ref) |-> $past(ce)); // R2
    AST_KIND_MATCHES_REF: assert property (@(posedge clk) disable iff (rst)
        ref_seen |-> (is_eav ^ is_sav)); // R4
    AST_KIND_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
        (is_eav || is_sav) |-> ref_seen); // R3
    AST_FIELD_HELD: assert property (@(posedge clk) disable iff (rst)
        !ref_seen |-> ($stable(field) && $stable(vblank))); // R5
    AST_BAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        bad_ref |-> !(ref_seen || is_eav || is_sav)); // R6
    AST_REF_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ref_seen |=> !ref_seen); // R9
    AST_BAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        bad_ref |=> !bad_ref); // R9
endmodule

bind sdi_trs_decoder sdi_trs_decoder_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .ref_seen (ref_seen),
    .is_eav   (is_eav),
    .is_sav   (is_sav),
    .bad_ref  (bad_ref),
    .field    (field),
    .vblank   (vblank)
);

// File: tb/sdi_trs_decoder_test.sv
module sdi_trs_decoder_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ce  = 1'b0;
    logic [9:0] din = '0;
    logic       ref_seen, is_eav, is_sav, bad_ref, field, vblank;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    sdi_trs_decoder uut (
        .clk(clk), .rst(rst), .ce(ce), .din(din),
        .ref_seen(ref_seen), .is_eav(is_eav), .is_sav(is_sav),
        .bad_ref(bad_ref), .field(field), .vblank(vblank)
    );

    // expected vector order: ref_seen, is_eav, is_sav, bad_ref, field, vblank
    task automatic expect_out(input string tag, input logic [5:0] want);
        logic [5:0] got;
        got = {ref_seen, is_eav, is_sav, bad_ref, field, vblank};
        n_run++;
        if (got !== want) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, got, want);
        end
    endtask

    task automatic put_word(input logic [9:0] w);
        din = w; ce = 1'b1;
        @(posedge clk); #1;
        ce = 1'b0; din = 10'h155;
    endtask

    task automatic idle();
        ce = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic preamble();
        put_word(10'h3FF); put_word(10'h000); put_word(10'h000);
    endtask

    task automatic do_reset();
        rst = 1'b1; idle(); idle(); rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        expect_out("R1 reset state", 6'b000000);
        put_word(10'h3FF); put_word(10'h000);
        rst = 1'b1; idle(); rst = 1'b0;
        put_word(10'h000); put_word(10'h200);
        expect_out("R1 partial preamble cleared by reset", 6'b000000);
    endtask

    task automatic t_all_legal();
        logic [9:0] codes [8] = '{10'h274, 10'h2D8, 10'h368, 10'h3C4,
                                  10'h200, 10'h2AC, 10'h31C, 10'h3B0};
        for (int i = 0; i < 8; i++) begin
            logic e, f, v;
            e = (i < 4);
            f = ((i % 4) >= 2);
            v = (i % 2) == 1;
            preamble();
            put_word(codes[i]);
            expect_out($sformatf("R3 R4 R5 code %h", codes[i]), {1'b1, e, !e, 1'b0, f, v});
            idle();
            expect_out($sformatf("R9 R5 after code %h", codes[i]), {4'b0000, f, v});
        end
    endtask

    task automatic t_illegal();
        preamble(); put_word(10'h3C4);
        expect_out("R6 setup", 6'b110011);
        preamble(); put_word(10'h201);
        expect_out("R6 illegal 0x201", 6'b000111);
        idle();
        expect_out("R9 bad pulse ends", 6'b000011);
        preamble(); put_word(10'h000);
        expect_out("R6 illegal 0x000", 6'b000111);
        preamble(); put_word(10'h270);
        expect_out("R6 bad protection", 6'b000111);
    endtask

    task automatic t_ce_gap();
        put_word(10'h3FF); idle(); din = 10'h123; idle();
        put_word(10'h000); din = 10'h3FF; idle(); idle();
        put_word(10'h000); din = 10'h2AC; idle();
        expect_out("R2 no pulse while ce low", 6'b000011);
        put_word(10'h2AC);
        expect_out("R2 preamble across ce gaps", 6'b101001);
    endtask

    task automatic t_restart();
        put_word(10'h3FF); put_word(10'h000); put_word(10'h3FF);
        put_word(10'h000); put_word(10'h000); put_word(10'h31C);
        expect_out("R7 restart after 3FF 000", 6'b101010);
        put_word(10'h3FF); put_word(10'h3FF); put_word(10'h000);
        put_word(10'h000); put_word(10'h274);
        expect_out("R7 repeated 3FF", 6'b110000);
        preamble(); put_word(10'h3FF);
        expect_out("R7 3FF as fourth word is bad", 6'b000100);
        put_word(10'h000); put_word(10'h000); put_word(10'h3B0);
        expect_out("R7 fourth-word 3FF restarts", 6'b101011);
    endtask

    task automatic t_broken();
        put_word(10'h3FF); put_word(10'h000); put_word(10'h001);
        put_word(10'h000); put_word(10'h200);
        expect_out("R8 broken zero word", 6'b000011);
        put_word(10'h3FF); put_word(10'h040); put_word(10'h000);
        put_word(10'h000); put_word(10'h200);
        expect_out("R8 broken first zero", 6'b000011);
        put_word(10'h000); put_word(10'h000); put_word(10'h274);
        expect_out("R8 zeros without ones", 6'b000011);
    endtask

    initial begin
        #2_000_000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        t_reset();
        t_all_legal();
        t_illegal();
        t_ce_gap();
        t_restart();
        t_broken();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule